// File: doc/BRIEF.md
# Instruction fault status encoder

This block builds the 32-bit status word that describes the most recent instruction-fetch abort and holds it in a register. When the fetch side reports a fault with a one-cycle strobe, the block takes the fault class, the lookup level, an external-abort classification bit and an address-invalid flag. It encodes them into one of two layouts, short or extended, chosen by a format input sampled with the strobe. It stores the result one clock later.

The two layouts place the fault code in different bits. In the short layout the 5-bit code is split into two non-contiguous pieces. In the extended layout the 6-bit code is contiguous. The address-invalid and external-classification flags are kept only for the fault classes they apply to. Any combination of class and level that the chosen layout cannot express is rejected: the register is left untouched and a one-cycle error pulse is raised.

Software can overwrite the word through a write port. A capture strobe takes the cycle over a write that arrives in the same cycle. Bits outside the active layout read as zero in every case.

Top module: `ifsr_encoder`

## Requirements
- R1: After `rst_ni` is released, `status_o` is 0x00000000 and `encode_err_o` is 0.
- R2: Short layout (`long_fmt_i`=0): an accepted capture stores the 5-bit code with bit 4 at status bit 10 and bits 3:0 at status bits 3:0, with status bit 9 = 0. The class codes on `fault_class_i` are: 0 pc-alignment, 1 debug, 2 translation, 3 access-flag, 4 permission, 5 domain, 6 external not on walk, 7 external on walk, 8 TLB conflict, 9 lockdown, 10 parity not on walk, 11 parity on walk, 12 address-size. `fault_level_i` gives the level number. The short codes are: alignment 00001, debug 00010, translation L1/L2 00101/00111, access-flag L1/L2 00011/00110, permission L1/L2 01101/01111, domain L1/L2 01001/01011, external not-walk 01000, external walk L1/L2 01100/01110, TLB 10000, lockdown 10100, parity not-walk 11001, parity walk L1/L2 11100/11110.
- R3: Extended layout (`long_fmt_i`=1): the 6-bit code is stored in status bits 5:0 and status bit 9 = 1. Each levelled class is a 4-bit prefix followed by the 2-bit level: address-size 0000 (levels 0-3), translation 0001, access-flag 0010, permission 0011, external walk 0101, parity walk 0111 (levels 1-3 for all but address-size). The other codes are external not-walk 010000, parity not-walk 011000, alignment 100001, debug 100010 and TLB 110000.
- R4: Every bit outside the active layout reads as zero. The short layout keeps bits 16, 12, 10, 9 and 3:0. The extended layout keeps bits 16, 12, 9 and 5:0.
- R5: Status bit 16 takes `addr_invalid_i` only for class 6. For every other class it is 0.
- R6: Status bit 12 takes `ext_class_i` only for classes 6 and 7. For every other class it is 0.
- R7: A strobe with a combination the chosen layout cannot encode sets `encode_err_o` for the one cycle after the strobe and leaves `status_o` unchanged. Unencodable combinations are: a wrong level, classes 12-15 in the short layout, classes 5, 9 and 13-15 in the extended layout, and class 13-15 in either.
- R8: With parameter `RAS_EN`=1, classes 10 and 11 are treated as unencodable in both layouts.
- R9: A software write with no strobe stores `sw_wdata_i` one cycle later. The mask of R4 is applied, chosen by bit 9 of the written data.
- R10: When `fault_valid_i` and `sw_we_i` are high in the same cycle, the write is dropped, whether or not the capture is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_valid_i | input | 1 | Fault capture strobe |
| fault_class_i | input | 4 | Fault class code |
| fault_level_i | input | 2 | Lookup level of the fault |
| ext_class_i | input | 1 | External-abort classification bit |
| addr_invalid_i | input | 1 | Fault address is not valid |
| long_fmt_i | input | 1 | 1 selects the extended layout |
| sw_we_i | input | 1 | Software write enable |
| sw_wdata_i | input | 32 | Software write data |
| status_o | output | 32 | Stored fault status word |
| encode_err_o | output | 1 | Unencodable capture, one-cycle pulse |

## Verification
The assertions check on every cycle that a word is never left with reserved bits set, and that after any capture the address-invalid bit appears only with the external not-on-walk code. They also check that the classification bit appears only with an external-abort code, and that an error pulse always follows a strobe and coincides with an unchanged word. Only the directed scenarios can show that each class and level maps to its exact code. The same holds for the write masking keyed on bit 9, for the write being dropped on a collision, and for the parity classes being refused in the reliability-extension build.

// File: rtl/ifsr_enc_pkg.sv
package ifsr_enc_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned SCODE_W = 5;
  localparam int unsigned LCODE_W = 6;
  localparam int unsigned CLASS_W = 4;
  localparam int unsigned LVL_W   = 2;
  localparam int unsigned FMT_BIT = 9;
  localparam int unsigned EXT_BIT = 12;
  localparam int unsigned FNV_BIT = 16;
  localparam int unsigned SHI_BIT = 10;

  typedef enum logic [CLASS_W-1:0] {
    FC_ALIGN    = 4'd0,
    FC_DEBUG    = 4'd1,
    FC_TRANS    = 4'd2,
    FC_ACCFLAG  = 4'd3,
    FC_PERM     = 4'd4,
    FC_DOMAIN   = 4'd5,
    FC_EXT_NW   = 4'd6,
    FC_EXT_WALK = 4'd7,
    FC_TLB      = 4'd8,
    FC_LOCKDOWN = 4'd9,
    FC_PAR_NW   = 4'd10,
    FC_PAR_WALK = 4'd11,
    FC_ADDRSZ   = 4'd12
  } fclass_e;

  // bits that survive for a given layout
  function automatic logic [WORD_W-1:0] keep_mask(input logic long_fmt);
    logic [WORD_W-1:0] m;
    m = '0;
    m[FNV_BIT] = 1'b1;
    m[EXT_BIT] = 1'b1;
    m[FMT_BIT] = 1'b1;
    if (long_fmt) begin
      m[LCODE_W-1:0] = '1;
    end else begin
      m[SHI_BIT] = 1'b1;
      m[SCODE_W-2:0] = '1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ifsr_short_enc.sv
module ifsr_short_enc import ifsr_enc_pkg::*; #(
  parameter bit RAS_EN = 1'b0
) (
  input  fclass_e            cls_i,
  input  logic [LVL_W-1:0]   lvl_i,
  output logic [SCODE_W-1:0] code_o,
  output logic               ok_o
);
  logic par_ok;
  logic lv12, l2;

  if (RAS_EN) begin : g_ras
    assign par_ok = 1'b0;
  end else begin : g_no_ras
    assign par_ok = 1'b1;
  end

  assign lv12 = (lvl_i == LVL_W'(1)) || (lvl_i == LVL_W'(2));
  assign l2   = (lvl_i == LVL_W'(2));

  always_comb begin
    code_o = '0;
    ok_o   = 1'b0;
    unique case (cls_i)
      FC_ALIGN:    begin code_o = 5'b00001; ok_o = 1'b1; end
      FC_DEBUG:    begin code_o = 5'b00010; ok_o = 1'b1; end
      FC_EXT_NW:   begin code_o = 5'b01000; ok_o = 1'b1; end
      FC_TLB:      begin code_o = 5'b10000; ok_o = 1'b1; end
      FC_LOCKDOWN: begin code_o = 5'b10100; ok_o = 1'b1; end
      FC_PAR_NW:   begin code_o = 5'b11001; ok_o = par_ok; end
      FC_TRANS:    begin code_o = {3'b001, l2, 1'b1}; ok_o = lv12; end
      FC_ACCFLAG:  begin code_o = l2 ? 5'b00110 : 5'b00011; ok_o = lv12; end
      FC_DOMAIN:   begin code_o = {3'b010, l2, 1'b1}; ok_o = lv12; end
      FC_PERM:     begin code_o = {3'b011, l2, 1'b1}; ok_o = lv12; end
      FC_EXT_WALK: begin code_o = {3'b011, l2, 1'b0}; ok_o = lv12; end
      FC_PAR_WALK: begin code_o = {3'b111, l2, 1'b0}; ok_o = lv12 && par_ok; end
      default:     begin code_o = '0; ok_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/ifsr_long_enc.sv
module ifsr_long_enc import ifsr_enc_pkg::*; #(
  parameter bit RAS_EN = 1'b0
) (
  input  fclass_e            cls_i,
  input  logic [LVL_W-1:0]   lvl_i,
  output logic [LCODE_W-1:0] code_o,
  output logic               ok_o
);
  localparam int unsigned PFX_W = LCODE_W - LVL_W;

  logic par_ok;
  logic lv123;

  if (RAS_EN) begin : g_ras
    assign par_ok = 1'b0;
  end else begin : g_no_ras
    assign par_ok = 1'b1;
  end

  assign lv123 = (lvl_i != '0);

  always_comb begin
    code_o = '0;
    ok_o   = 1'b0;
    unique case (cls_i)
      FC_ALIGN:    begin code_o = 6'b100001; ok_o = 1'b1; end
      FC_DEBUG:    begin code_o = 6'b100010; ok_o = 1'b1; end
      FC_EXT_NW:   begin code_o = 6'b010000; ok_o = 1'b1; end
      FC_TLB:      begin code_o = 6'b110000; ok_o = 1'b1; end
      FC_PAR_NW:   begin code_o = 6'b011000; ok_o = par_ok; end
      FC_ADDRSZ:   begin code_o = {PFX_W'(4'b0000), lvl_i}; ok_o = 1'b1; end
      FC_TRANS:    begin code_o = {PFX_W'(4'b0001), lvl_i}; ok_o = lv123; end
      FC_ACCFLAG:  begin code_o = {PFX_W'(4'b0010), lvl_i}; ok_o = lv123; end
      FC_PERM:     begin code_o = {PFX_W'(4'b0011), lvl_i}; ok_o = lv123; end
      FC_EXT_WALK: begin code_o = {PFX_W'(4'b0101), lvl_i}; ok_o = lv123; end
      FC_PAR_WALK: begin code_o = {PFX_W'(4'b0111), lvl_i}; ok_o = lv123 && par_ok; end
      default:     begin code_o = '0; ok_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/ifsr_word_pack.sv
module ifsr_word_pack import ifsr_enc_pkg::*; (
  input  logic               long_fmt_i,
  input  fclass_e            cls_i,
  input  logic [SCODE_W-1:0] scode_i,
  input  logic [LCODE_W-1:0] lcode_i,
  input  logic               ext_class_i,
  input  logic               addr_inv_i,
  output logic [WORD_W-1:0]  word_o
);
  logic is_ext_nw, is_ext;

  assign is_ext_nw = (cls_i == FC_EXT_NW);
  assign is_ext    = is_ext_nw || (cls_i == FC_EXT_WALK);

  always_comb begin
    word_o = '0;
    if (long_fmt_i) begin
      word_o[LCODE_W-1:0] = lcode_i;
    end else begin
      word_o[SHI_BIT]       = scode_i[SCODE_W-1];
      word_o[SCODE_W-2:0]   = scode_i[SCODE_W-2:0];
    end
    word_o[FMT_BIT] = long_fmt_i;
    word_o[EXT_BIT] = ext_class_i && is_ext;
    word_o[FNV_BIT] = addr_inv_i && is_ext_nw;
  end
endmodule

// File: rtl/ifsr_encoder.sv
module ifsr_encoder import ifsr_enc_pkg::*; #(
  parameter bit RAS_EN = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fault_valid_i,
  input  logic [CLASS_W-1:0] fault_class_i,
  input  logic [LVL_W-1:0]   fault_level_i,
  input  logic               ext_class_i,
  input  logic               addr_invalid_i,
  input  logic               long_fmt_i,
  input  logic               sw_we_i,
  input  logic [WORD_W-1:0]  sw_wdata_i,
  output logic [WORD_W-1:0]  status_o,
  output logic               encode_err_o
);
  fclass_e            cls;
  logic [SCODE_W-1:0] scode;
  logic [LCODE_W-1:0] lcode;
  logic               s_ok, l_ok, enc_ok;
  logic [WORD_W-1:0]  cap_word;
  logic [WORD_W-1:0]  word_q;
  logic               err_q;

  assign cls = fclass_e'(fault_class_i);

  ifsr_short_enc #(.RAS_EN(RAS_EN)) u_short (
    .cls_i(cls), .lvl_i(fault_level_i), .code_o(scode), .ok_o(s_ok)
  );

  ifsr_long_enc #(.RAS_EN(RAS_EN)) u_long (
    .cls_i(cls), .lvl_i(fault_level_i), .code_o(lcode), .ok_o(l_ok)
  );

  ifsr_word_pack u_pack (
    .long_fmt_i(long_fmt_i), .cls_i(cls), .scode_i(scode), .lcode_i(lcode),
    .ext_class_i(ext_class_i), .addr_inv_i(addr_invalid_i), .word_o(cap_word)
  );

  assign enc_ok = long_fmt_i ? l_ok : s_ok;

  // capture owns the cycle even when rejected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= fault_valid_i && !enc_ok;
      if (fault_valid_i) begin
        if (enc_ok) word_q <= cap_word;
      end else if (sw_we_i) begin
        word_q <= sw_wdata_i & keep_mask(sw_wdata_i[FMT_BIT]);
      end
    end
  end

  assign status_o     = word_q;
  assign encode_err_o = err_q;

  // R4
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~keep_mask(status_o[FMT_BIT])) == '0);

  // R5
  fnv_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_i |=> (encode_err_o || !status_o[16] ||
      (status_o[9] ? (status_o[5:0] == 6'b010000)
                   : ({status_o[10], status_o[3:0]} == 5'b01000))));

  // R6
  ext_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_i |=> (encode_err_o || !status_o[12] ||
      (status_o[9] ? ((status_o[5:0] == 6'b010000) || (status_o[5:2] == 4'b0101))
                   : (({status_o[10], status_o[3:0]} == 5'b01000) ||
                      ({status_o[10], status_o[3:0]} == 5'b01100) ||
                      ({status_o[10], status_o[3:0]} == 5'b01110)))));

  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_i |=> (!encode_err_o || (status_o == $past(status_o))));

  // R7
  err_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    encode_err_o |-> $past(fault_valid_i));

  // R10
  cap_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_i && sw_we_i) |=> (encode_err_o || status_o[9] == $past(long_fmt_i)));
endmodule

// File: tb/tb_ifsr_encoder.sv
`timescale 1ns/1ps
module tb_ifsr_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fv = 1'b0;
  logic [3:0]  cls = '0;
  logic [1:0]  lvl = '0;
  logic        ext = 1'b0;
  logic        ainv = 1'b0;
  logic        lf = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] st, st_r;
  logic        err, err_r;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ifsr_encoder dut (
    .clk_i(clk), .rst_ni(rst_n), .fault_valid_i(fv), .fault_class_i(cls),
    .fault_level_i(lvl), .ext_class_i(ext), .addr_invalid_i(ainv),
    .long_fmt_i(lf), .sw_we_i(we), .sw_wdata_i(wd), .status_o(st), .encode_err_o(err)
  );

  ifsr_encoder #(.RAS_EN(1'b1)) dut_ras (
    .clk_i(clk), .rst_ni(rst_n), .fault_valid_i(fv), .fault_class_i(cls),
    .fault_level_i(lvl), .ext_class_i(ext), .addr_invalid_i(ainv),
    .long_fmt_i(lf), .sw_we_i(we), .sw_wdata_i(wd), .status_o(st_r), .encode_err_o(err_r)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, then sample at the following falling edge
  task automatic apply(input logic f, input logic [3:0] c, input logic [1:0] l,
                       input logic long_f, input logic e, input logic a,
                       input logic w, input logic [31:0] d);
    @(negedge clk);
    fv = f; cls = c; lvl = l; lf = long_f; ext = e; ainv = a; we = w; wd = d;
    @(negedge clk);
    fv = 1'b0; we = 1'b0;
  endtask

  task automatic cap(input logic [3:0] c, input logic [1:0] l, input logic long_f,
                     input logic e, input logic a);
    apply(1'b1, c, l, long_f, e, a, 1'b0, '0);
  endtask

  task automatic t_reset;
    chk("R1 status", st, 32'h0);
    chk("R1 err", {31'b0, err}, 32'h0);
  endtask

  task automatic t_short;
    cap(4'd2, 2'd1, 1'b0, 1'b0, 1'b0); chk("R2 trans L1", st, 32'h0000_0005);
    cap(4'd4, 2'd2, 1'b0, 1'b0, 1'b0); chk("R2 perm L2", st, 32'h0000_000F);
    cap(4'd3, 2'd2, 1'b0, 1'b0, 1'b0); chk("R2 accflag L2", st, 32'h0000_0006);
    cap(4'd8, 2'd0, 1'b0, 1'b0, 1'b0); chk("R2 tlb", st, 32'h0000_0400);
    cap(4'd11, 2'd2, 1'b0, 1'b0, 1'b0); chk("R2 parity walk L2", st, 32'h0000_040E);
    chk("R2 err", {31'b0, err}, 32'h0);
  endtask

  task automatic t_long;
    cap(4'd2, 2'd3, 1'b1, 1'b0, 1'b0); chk("R3 trans L3", st, 32'h0000_0207);
    cap(4'd3, 2'd1, 1'b1, 1'b0, 1'b0); chk("R3 accflag L1", st, 32'h0000_0209);
    cap(4'd8, 2'd0, 1'b1, 1'b0, 1'b0); chk("R3 tlb", st, 32'h0000_0230);
    cap(4'd12, 2'd0, 1'b1, 1'b0, 1'b0); chk("R3 addrsz L0", st, 32'h0000_0200);
    cap(4'd10, 2'd0, 1'b1, 1'b0, 1'b0); chk("R3 parity nowalk", st, 32'h0000_0218);
  endtask

  task automatic t_flags;
    cap(4'd6, 2'd0, 1'b0, 1'b1, 1'b1); chk("R5 R6 short ext nowalk", st, 32'h0001_1008);
    cap(4'd7, 2'd2, 1'b1, 1'b1, 1'b1); chk("R5 R6 long ext walk L2", st, 32'h0000_1216);
    cap(4'd0, 2'd0, 1'b1, 1'b1, 1'b1); chk("R5 R6 long align flags dropped", st, 32'h0000_0221);
    cap(4'd6, 2'd0, 1'b1, 1'b0, 1'b1); chk("R5 long fnv only", st, 32'h0001_0210);
  endtask

  task automatic t_errors;
    cap(4'd4, 2'd1, 1'b0, 1'b0, 1'b0);
    chk("R7 setup", st, 32'h0000_000D);
    cap(4'd2, 2'd3, 1'b0, 1'b0, 1'b0);
    chk("R7 short L3 err", {31'b0, err}, 32'h1); chk("R7 short L3 hold", st, 32'h0000_000D);
    cap(4'd5, 2'd1, 1'b1, 1'b0, 1'b0);
    chk("R7 long domain err", {31'b0, err}, 32'h1); chk("R7 long domain hold", st, 32'h0000_000D);
    cap(4'd12, 2'd1, 1'b0, 1'b0, 1'b0);
    chk("R7 short addrsz err", {31'b0, err}, 32'h1);
    cap(4'd13, 2'd1, 1'b1, 1'b0, 1'b0);
    chk("R7 class 13 err", {31'b0, err}, 32'h1); chk("R7 class 13 hold", st, 32'h0000_000D);
    @(negedge clk);
    chk("R7 err one cycle", {31'b0, err}, 32'h0);
  endtask

  task automatic t_ras;
    cap(4'd10, 2'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 ras parity err", {31'b0, err_r}, 32'h1);
    chk("R8 base parity ok", {31'b0, err}, 32'h0);
    chk("R8 base word", st, 32'h0000_0218);
    cap(4'd11, 2'd1, 1'b0, 1'b0, 1'b0);
    chk("R8 ras parity walk err", {31'b0, err_r}, 32'h1);
  endtask

  task automatic t_sw;
    apply(1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    chk("R9 R4 long mask", st, 32'h0001_123F);
    apply(1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FDFF);
    chk("R9 R4 short mask", st, 32'h0001_140F);
    apply(1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0000);
    chk("R9 clear", st, 32'h0);
  endtask

  task automatic t_collide;
    apply(1'b1, 4'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    chk("R10 capture wins", st, 32'h0000_0002);
    apply(1'b1, 4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    chk("R10 rejected capture drops write", st, 32'h0000_0002);
    chk("R10 err", {31'b0, err}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_long();
    t_flags();
    t_errors();
    t_ras();
    t_sw();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule